// File: doc/BRIEF.md
# Process-Tagged Address Translation Buffer with Table Walk

This block turns a logical address into a physical one for a paged memory. The logical address is split into a high-order page number and a low-order offset. The physical address is the frame number for that page placed directly above the offset, which is passed through unchanged. Recent page-to-frame pairs sit in a small, fully associative buffer. Each entry carries a valid bit, a process identifier, a page number and a frame number. A lookup hits only when the page number matches and the stored identifier equals the current-process register.

A hit answers on the cycle after the request is taken, and no memory is accessed. A miss deasserts `req_ready`. The block then issues one read to the page table in memory, at the table base register plus the page number. When the word comes back, the block answers with the fetched frame and writes the new pair into the buffer. An empty entry is always filled first. When every entry is valid, a rotating pointer names the victim. Software switches the block to another process by writing the process register and the table base register. A flush input clears the buffer in one cycle.

With the default parameters a 16-bit logical address carries a 3-bit page number and a 13-bit offset. There are 16 frames, so the physical address is 17 bits wide.

Top module: `xlat_unit`

## Requirements
- R1: The response address is `{frame, offset}`: bits [12:0] of `rsp_paddr` equal bits [12:0] of the accepted `req_laddr`, and bits [16:13] of `rsp_paddr` hold the 4-bit frame number.
- R2: A request accepted while its (current process, page) pair is in the buffer produces `rsp_valid` on the very next cycle. No `mem_rd` is issued, and `req_ready` stays high.
- R3: A request that misses raises `mem_rd` for one cycle on the cycle after acceptance. `mem_addr` then equals the table base register plus the page number (bits [15:13] of `req_laddr`), taken modulo 256.
- R4: From the acceptance of a miss until its response, `req_ready` is low. `rsp_valid` rises on the cycle after `mem_rvalid`, and its frame is `mem_rdata`.
- R5: After a miss completes, a request with the same page under the same process hits.
- R6: An entry whose stored process identifier differs from the current-process register never hits, even when the page number matches. The lookup is handled as a miss.
- R7: When any entry is invalid, a fill takes the lowest-numbered invalid entry, whatever the replacement pointer holds.
- R8: A cycle with `flush` high makes every entry invalid from the next cycle. If a fill falls in the same cycle, the flush wins.
- R9: When all entries are valid, a fill evicts the entry named by a rotating pointer. The pointer is 0 after reset. It advances by one, wrapping after the last entry, only when a valid entry is evicted. Flush does not move it.
- R10: A write to the process register or to the table base register applies to every request accepted after the write cycle. Changing the base makes later walks read a different table.
- R11: During and after reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd` is 0, and every buffer entry is invalid.
- R12: With page 2 mapped to frame 11, logical address 18325 translates to physical address 92053.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Invalidate all buffer entries |
| pid_we | input | 1 | Write strobe for the current-process register |
| pid_wdata | input | 4 | New current-process identifier |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 8 | New page-table base address |
| req_valid | input | 1 | Translation request present |
| req_laddr | input | 16 | Logical address to translate |
| req_ready | output | 1 | Block can take a request |
| rsp_valid | output | 1 | One-cycle pulse: translated address valid |
| rsp_paddr | output | 17 | Physical address |
| mem_rd | output | 1 | One-cycle read request to table memory |
| mem_addr | output | 8 | Word address of the page-table entry |
| mem_rdata | input | 4 | Frame number returned by memory |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after `mem_rd` |

## Verification
A corrupted tag or valid bit shows up in one of two ways at the ports. A hit may change into a miss, seen as an extra `mem_rd` and a response that comes several cycles late. Or a lookup may hit on a stale entry, which returns the wrong frame in the next-cycle response. A wrong replacement pointer or a wrong choice of invalid entry stays hidden until a later request to the evicted page. That request misses where a hit was expected, so the test sequences track the buffer contents precisely and probe evicted and surviving pages right after each fill. A broken offset path or a broken walk address corrupts the very next response.

// File: rtl/xlat_pkg.sv
// Shared types for the address translation unit.
// Assumes: included first in compile order.
package xlat_pkg;

    // States of the page-table walk sequencer.
    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_FETCH = 2'd1,
        WK_WAIT  = 2'd2
    } walk_st_e;

endpackage

// File: rtl/xlat_cam.sv
// Fully associative translation store. Each entry holds valid, process id,
// page and frame. Matches the lookup key on every entry at once, and returns
// the match vector and the frame of the matching entry.
// Assumes: at most one entry matches a key (the writer fills only on a miss).
module xlat_cam #(
    parameter int DEPTH = 4,
    parameter int PID_W = 4,
    parameter int PN_W  = 3,
    parameter int FR_W  = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [PN_W-1:0]  wr_pn,
    input  logic [FR_W-1:0]  wr_frame,
    input  logic [PID_W-1:0] lk_pid,
    input  logic [PN_W-1:0]  lk_pn,
    output logic [DEPTH-1:0] match_vec,
    output logic [DEPTH-1:0] valid_vec,
    output logic [FR_W-1:0]  hit_frame
);

    logic [DEPTH-1:0][FR_W-1:0] fr_bus;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic             v_q;
        logic [PID_W-1:0] pid_q;
        logic [PN_W-1:0]  pn_q;
        logic [FR_W-1:0]  fr_q;

        // Entry storage: flush clears valid, and a write loads the whole entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                pid_q <= '0;
                pn_q  <= '0;
                fr_q  <= '0;
            end else if (flush) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                v_q   <= 1'b1;
                pid_q <= wr_pid;
                pn_q  <= wr_pn;
                fr_q  <= wr_frame;
            end
        end

        assign match_vec[g] = v_q && (pid_q == lk_pid) && (pn_q == lk_pn);
        assign valid_vec[g] = v_q;
        assign fr_bus[g]    = fr_q;
    end

    // Select the frame of the matching entry (an OR over one-hot candidates).
    always_comb begin
        hit_frame = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_vec[i]) hit_frame = hit_frame | fr_bus[i];
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Chooses the entry that the next fill writes. The lowest-numbered invalid
// entry comes first. When all entries are valid, a rotating pointer names the
// victim, and it advances only when a valid entry is actually evicted.
// Assumes: 'fill' is high exactly on the cycles the store is written.
module xlat_victim #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] valid_vec,
    input  logic             fill,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_q;
    logic             all_valid;

    assign all_valid = &valid_vec;

    // Pick the lowest invalid slot. Fall back to the pointer when full.
    always_comb begin
        victim_idx = rr_q;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end

    // Rotate the pointer on each eviction of a valid entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill && all_valid) begin
            rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + IDX_W'(1);
        end
    end

endmodule

// File: rtl/xlat_walk.sv
// Walk sequencer for a miss: one cycle issuing the table read, then waiting
// for the returned word. Busy for the whole walk.
// Assumes: memory answers at least one cycle after the read strobe.
module xlat_walk
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_rvalid,
    output logic busy,
    output logic mem_rd,
    output logic done
);

    walk_st_e st_q;

    // Next-state register of the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= WK_IDLE;
        end else begin
            case (st_q)
                WK_IDLE:  if (start) st_q <= WK_FETCH;
                WK_FETCH: st_q <= WK_WAIT;
                WK_WAIT:  if (mem_rvalid) st_q <= WK_IDLE;
                default:  st_q <= WK_IDLE;
            endcase
        end
    end

    // Decoded outputs of the walk state.
    always_comb begin
        busy   = (st_q != WK_IDLE);
        mem_rd = (st_q == WK_FETCH);
        done   = (st_q == WK_WAIT) && mem_rvalid;
    end

endmodule

// File: rtl/xlat_unit.sv
// Top of the translation unit. Holds the process and table base registers,
// looks each request up in the tagged store, answers hits on the next cycle,
// and on a miss walks the in-memory page table and fills the store.
// Assumes: one request in flight at a time (req_ready is low during a walk).
module xlat_unit #(
    parameter int LA_W  = 16,
    parameter int PN_W  = 3,
    parameter int FR_W  = 4,
    parameter int PID_W = 4,
    parameter int MA_W  = 8,
    parameter int DEPTH = 4,
    localparam int OFF_W = LA_W - PN_W,
    localparam int PA_W  = FR_W + OFF_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pid_we,
    input  logic [PID_W-1:0] pid_wdata,
    input  logic             base_we,
    input  logic [MA_W-1:0]  base_wdata,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_laddr,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_rd,
    output logic [MA_W-1:0]  mem_addr,
    input  logic [FR_W-1:0]  mem_rdata,
    input  logic             mem_rvalid
);

    logic [PID_W-1:0] pid_q;
    logic [MA_W-1:0]  base_q;
    logic [LA_W-1:0]  lat_laddr;
    logic [PID_W-1:0] lat_pid;
    logic [DEPTH-1:0] match_vec;
    logic [DEPTH-1:0] valid_vec;
    logic [FR_W-1:0]  hit_frame;
    logic [IDX_W-1:0] victim_idx;
    logic             cam_hit;
    logic             accept;
    logic             walk_busy;
    logic             walk_done;
    logic             wr_en;

    assign cam_hit   = |match_vec;
    assign req_ready = !walk_busy;
    assign accept    = req_valid && req_ready;
    assign wr_en     = walk_done && !flush;
    assign mem_addr  = base_q + {{(MA_W - PN_W){1'b0}}, lat_laddr[LA_W-1:OFF_W]};

    // Software-visible process id and page-table base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_q  <= '0;
            base_q <= '0;
        end else begin
            if (pid_we)  pid_q  <= pid_wdata;
            if (base_we) base_q <= base_wdata;
        end
    end

    // Capture the accepted request for use by the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_laddr <= '0;
            lat_pid   <= '0;
        end else if (accept) begin
            lat_laddr <= req_laddr;
            lat_pid   <= pid_q;
        end
    end

    // Response register: a hit answers next cycle, a walk answers on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= (accept && cam_hit) || walk_done;
            if (accept && cam_hit) begin
                rsp_paddr <= {hit_frame, req_laddr[OFF_W-1:0]};
            end else if (walk_done) begin
                rsp_paddr <= {mem_rdata, lat_laddr[OFF_W-1:0]};
            end
        end
    end

    xlat_cam #(
        .DEPTH (DEPTH),
        .PID_W (PID_W),
        .PN_W  (PN_W),
        .FR_W  (FR_W)
    ) i_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .wr_idx    (victim_idx),
        .wr_pid    (lat_pid),
        .wr_pn     (lat_laddr[LA_W-1:OFF_W]),
        .wr_frame  (mem_rdata),
        .lk_pid    (pid_q),
        .lk_pn     (req_laddr[LA_W-1:OFF_W]),
        .match_vec (match_vec),
        .valid_vec (valid_vec),
        .hit_frame (hit_frame)
    );

    xlat_victim #(
        .DEPTH (DEPTH)
    ) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .fill       (wr_en),
        .victim_idx (victim_idx)
    );

    xlat_walk i_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && !cam_hit),
        .mem_rvalid (mem_rvalid),
        .busy       (walk_busy),
        .mem_rd     (mem_rd),
        .done       (walk_done)
    );

endmodule

// File: rtl/xlat_chk.sv
// Property checker for xlat_unit, attached with bind. Tracks the offset of the
// accepted request on its own so that responses can be compared with it.
// Assumes: same parameters as the bound instance.
module xlat_chk #(
    parameter int LA_W  = 16,
    parameter int PN_W  = 3,
    parameter int FR_W  = 4,
    parameter int MA_W  = 8,
    parameter int DEPTH = 4,
    localparam int OFF_W = LA_W - PN_W,
    localparam int PA_W  = FR_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LA_W-1:0]  req_laddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             mem_rd,
    input logic [MA_W-1:0]  mem_addr,
    input logic             mem_rvalid,
    input logic             cam_hit,
    input logic [DEPTH-1:0] match_vec,
    input logic [DEPTH-1:0] valid_vec,
    input logic [MA_W-1:0]  base_q
);

    logic [OFF_W-1:0] off_q;

    // Offset of the most recently accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_laddr[OFF_W-1:0];
    end

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_paddr[OFF_W-1:0] == off_q));

    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cam_hit) |=> (rsp_valid && !mem_rd));

    a_r3_walk_address: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cam_hit) |=>
            (mem_rd && (mem_addr == MA_W'(base_q +
                {{(MA_W - PN_W){1'b0}}, $past(req_laddr[LA_W-1:OFF_W])}))));

    a_r4_stall_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);

    a_r4_answer_on_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && mem_rvalid) |=> rsp_valid);

    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_valid && !mem_rd && (valid_vec == '0)));

endmodule

bind xlat_unit xlat_chk #(
    .LA_W  (LA_W),
    .PN_W  (PN_W),
    .FR_W  (FR_W),
    .MA_W  (MA_W),
    .DEPTH (DEPTH)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_laddr  (req_laddr),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .cam_hit    (cam_hit),
    .match_vec  (match_vec),
    .valid_vec  (valid_vec),
    .base_q     (base_q)
);

// File: tb/test_xlat_unit.sv
// Scoreboard bench for xlat_unit: the driver queues expected results, and a
// monitor checks each response and whether a table read came before it.
module test_xlat_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        pid_we = 1'b0;
    logic [3:0]  pid_wdata = '0;
    logic        base_we = 1'b0;
    logic [7:0]  base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_laddr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [16:0] rsp_paddr;
    logic        mem_rd;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    int checks = 0;
    int fails  = 0;

    logic [3:0]  mem [256];
    logic [16:0] exp_pa_q [$];
    bit          exp_miss_q [$];
    string       tag_q [$];
    bit          saw_rd = 1'b0;
    logic [7:0]  base_model = '0;
    int          mcnt = 0;
    logic [7:0]  maddr = '0;

    always #5 clk = ~clk;

    xlat_unit i_xlat_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .pid_we     (pid_we),
        .pid_wdata  (pid_wdata),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .req_valid  (req_valid),
        .req_laddr  (req_laddr),
        .req_ready  (req_ready),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .mem_rvalid (mem_rvalid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] frame_of(input logic [7:0] b, input logic [2:0] p);
        return mem[b + {5'b0, p}];
    endfunction

    function automatic logic [15:0] la(input int p, input int off);
        return {3'(p), 13'(off)};
    endfunction

    // Table memory: answers a read three cycles after the strobe.
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (!rst_n) begin
            mcnt = 0;
        end else if (mem_rd) begin
            mcnt  = 3;
            maddr = mem_addr;
        end else if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[maddr];
            end
        end
    end

    // Monitor: pop one expected item for each response.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) saw_rd = 1'b1;
            if (rsp_valid) begin
                if (exp_pa_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected response", int'(rsp_paddr), -1);
                end else begin
                    logic [16:0] epa;
                    bit          emiss;
                    string       tg;
                    epa   = exp_pa_q.pop_front();
                    emiss = exp_miss_q.pop_front();
                    tg    = tag_q.pop_front();
                    chk(rsp_paddr == epa, tg, "physical address", int'(rsp_paddr), int'(epa));
                    chk(saw_rd == emiss, tg, "table read before response (1=miss)",
                        int'(saw_rd), int'(emiss));
                end
                saw_rd = 1'b0;
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!req_ready || exp_pa_q.size() != 0) @(negedge clk);
    endtask

    task automatic issue_exp(input logic [15:0] a, input logic [16:0] pa,
                             input bit miss, input string tag);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_laddr = a;
        exp_pa_q.push_back(pa);
        exp_miss_q.push_back(miss);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic issue(input logic [15:0] a, input bit miss, input string tag);
        issue_exp(a, {frame_of(base_model, a[15:13]), a[12:0]}, miss, tag);
    endtask

    task automatic set_pid(input logic [3:0] v);
        wait_idle();
        pid_we = 1'b1; pid_wdata = v;
        @(negedge clk);
        pid_we = 1'b0;
    endtask

    task automatic set_base(input logic [7:0] v);
        wait_idle();
        base_we = 1'b1; base_wdata = v; base_model = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic do_flush();
        wait_idle();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 4'(a ^ 5);
        for (int p = 0; p < 8; p++) begin
            mem[8'h10 + p] = (p == 2) ? 4'd11 : 4'((p * 5 + 3) % 16);
            mem[8'h40 + p] = 4'((p * 7 + 1) % 16);
        end

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "req_ready in reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
        chk(mem_rd == 1'b0, "R11", "mem_rd in reset", int'(mem_rd), 0);
        rst_n = 1'b1;

        set_base(8'h10);
        set_pid(4'd1);
        // R12 worked example, also first miss after reset (R11, R3, R4)
        issue_exp(16'd18325, 17'd92053, 1'b1, "R12");
        issue(16'd18325, 1'b0, "R2");
        // fill the rest: p2@0, p0@1, p1@2, p3@3
        issue(la(0, 1), 1'b1, "R5");
        issue(la(1, 13'h1FFF), 1'b1, "R1");
        issue(la(3, 0), 1'b1, "R1");
        issue(la(0, 13'h0ABC), 1'b0, "R5");
        // R9: full, pointer at 0 evicts page 2
        issue(la(4, 77), 1'b1, "R9");
        issue(la(0, 5), 1'b0, "R9");
        issue(la(1, 6), 1'b0, "R9");
        issue(la(3, 7), 1'b0, "R9");
        issue(la(4, 8), 1'b0, "R9");
        issue(la(2, 9), 1'b1, "R9");   // evicts slot1 (page 0)
        issue(la(0, 10), 1'b1, "R9");  // evicts slot2 (page 1)
        issue(la(3, 11), 1'b0, "R9");
        issue(la(1, 12), 1'b1, "R9");  // evicts slot3 (page 3), pointer wraps
        issue(la(2, 13), 1'b0, "R9");
        // R6: process tag
        set_pid(4'd2);
        issue(la(4, 14), 1'b1, "R6");  // evicts slot0
        set_pid(4'd1);
        issue(la(4, 15), 1'b1, "R6");  // evicts slot1, pointer now 2
        set_pid(4'd2);
        issue(la(4, 16), 1'b0, "R6");
        // R8: flush
        do_flush();
        issue(la(4, 17), 1'b1, "R8");  // slot0
        // R7: invalid first, pointer still 2
        issue(la(5, 18), 1'b1, "R7");  // slot1
        issue(la(6, 19), 1'b1, "R7");  // slot2
        issue(la(7, 20), 1'b1, "R7");  // slot3
        issue(la(4, 21), 1'b0, "R7");
        issue(la(5, 22), 1'b0, "R7");
        issue(la(7, 23), 1'b0, "R7");
        issue(la(0, 24), 1'b1, "R7");  // evicts slot2 (page 6)
        issue(la(4, 25), 1'b0, "R7");
        issue(la(5, 26), 1'b0, "R7");
        issue(la(6, 27), 1'b1, "R7");
        // R10: switch table and process
        set_base(8'h40);
        do_flush();
        set_pid(4'd3);
        issue(la(2, 28), 1'b1, "R10");
        issue(la(2, 29), 1'b0, "R10");
        issue(la(6, 13'h1234), 1'b1, "R10");

        for (int i = 0; i < 50 && exp_pa_q.size() != 0; i++) @(negedge clk);
        chk(exp_pa_q.size() == 0, "R4", "responses outstanding", exp_pa_q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

endmodule